// File: doc/BRIEF.md
# Interrupt Acknowledge Call Sequencer

This block answers the processor's interrupt acknowledge pulses with a three-byte call sequence. On the first pulse it puts a call opcode on the data bus and tells the priority core which level it has taken. On the second pulse it puts out the low byte of that level's handler address, and on the third pulse the high byte. The low byte is built from a programmed base byte, a call spacing of four or eight bytes, and the level number. The high byte is a second programmed byte. The base bytes, the spacing, the automatic end-of-interrupt option and the cascade settings are static inputs, written by register logic outside this block.

A unit can run in one of three roles. A single unit works on its own. A master puts the slave identifier on three cascade lines when the level it accepted has a slave behind it. A slave compares those lines with its own identifier. The master always supplies the opcode. For a level that has a slave, the address bytes come from the slave that the identifier selects. The data bus is split into a data output and an output enable, and the enable is high only during an acknowledge pulse in which this unit drives the bus. If no unmasked request is pending when a unit takes its level, it supplies the level-7 address as a spurious vector and marks no level as in service.

Top module: `iack_seq`

## Requirements
- R1: After reset the sequencer expects a first pulse. `data_oe_o`, `accept_o` and `eoi_o` are low, and `cas_o` is 0.
- R2: A single unit or a master drives 8'hCD during every first pulse. If `req_valid_i` is high when that pulse rises, `accept_o` is high until the next clock edge, and `accept_level_o` equals `req_level_i`.
- R3: When `interval8_i` is 0, the second pulse drives the low byte {base[7:5], level, 2'b00}.
- R4: When `interval8_i` is 1, the second pulse drives the low byte {base[7:6], level, 3'b000}.
- R5: The third pulse drives `vec_high_i`.
- R6: When `auto_eoi_i` is 1 and a level was accepted, `eoi_o` pulses at the rise of the third pulse, with `eoi_level_o` set to the accepted level. When `auto_eoi_i` is 0, `eoi_o` stays low.
- R7: If `req_valid_i` is low when the level is taken, `accept_o` stays low, the low byte is formed with level 7, and `eoi_o` stays low.
- R8: `data_oe_o` is high only while `inta_i` is high. After the third pulse ends, the next pulse is again treated as a first pulse.
- R9: A master with `cascade_en_i`=1, whose accepted level has its bit set in `slave_map_i`, drives that level on `cas_o` from the clock edge after the first pulse rises until the third pulse ends. It does not drive the bus on the second or third pulse. `cas_o` is 0 when cascading is disabled.
- R10: A slave never drives the bus during the first pulse. If `cas_i` equals `own_id_i` when the first pulse falls, it raises `accept_o` at that fall and drives the second and third bytes. Otherwise it stays silent and accepts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inta_i | input | 1 | Interrupt acknowledge pulse, active high |
| req_valid_i | input | 1 | Priority core has an unmasked winner |
| req_level_i | input | 3 | Winning level from the priority core |
| vec_base_i | input | 8 | Programmed low address base |
| vec_high_i | input | 8 | Programmed high address byte |
| interval8_i | input | 1 | 1: spacing of 8 bytes, 0: spacing of 4 bytes |
| auto_eoi_i | input | 1 | Release the in-service level on the third pulse |
| cascade_en_i | input | 1 | Cascade operation enabled |
| master_i | input | 1 | Master role when cascading |
| slave_map_i | input | 8 | Levels that have a slave attached (master) |
| own_id_i | input | 3 | Identifier of this unit (slave) |
| cas_i | input | 3 | Cascade lines seen by a slave |
| cas_o | output | 3 | Cascade lines driven by a master |
| accept_o | output | 1 | Set in-service and clear request for the level |
| accept_level_o | output | 3 | Level being accepted |
| eoi_o | output | 1 | Automatic release of the in-service level |
| eoi_level_o | output | 3 | Level to release |
| data_o | output | 8 | Data bus value |
| data_oe_o | output | 1 | Data bus enable |

## Verification
A pulse counter that is off by one shows on the very next pulse. The byte seen there is the opcode, the low byte or the high byte where a different one was due, and after the third pulse the sequence does not start again at the opcode. A wrongly latched level or spurious flag shows on the second pulse as a wrong level field, and at the rise of the third pulse as a missing or extra release. A wrong slave selection or cascade flag shows within the same sequence, because the bus enable is set or cleared in the wrong role, or `cas_o` shows a stale identifier after the third pulse.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [1:0] {PH_FIRST = 2'd0, PH_LOW = 2'd1, PH_HIGH = 2'd2} ph_e;
  localparam logic [7:0] CALL_OP = 8'hCD;
endpackage

// File: rtl/iack_phase.sv
module iack_phase
  import iack_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inta_i,
  output logic rise_o,
  output logic fall_o,
  output ph_e  phase_o
);
  logic inta_q;
  ph_e  phase_q;

  assign rise_o  = inta_i & ~inta_q;
  assign fall_o  = inta_q & ~inta_i;
  assign phase_o = phase_q;

  // phase counts finished pulses; advances on the falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inta_q  <= 1'b0;
      phase_q <= PH_FIRST;
    end else begin
      inta_q <= inta_i;
      if (fall_o) phase_q <= (phase_q == PH_HIGH) ? PH_FIRST : ph_e'(phase_q + 2'd1);
    end
  end

  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o && phase_q == PH_HIGH) |=> phase_q == PH_FIRST); // R8
  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3); // R8
endmodule

// File: rtl/iack_vector.sv
module iack_vector
  import iack_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  ph_e           phase_i,
  input  logic [LW-1:0] level_i,
  input  logic          interval8_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] high_i,
  output logic [DW-1:0] byte_o
);
  logic [DW-1:0] lo4, lo8;
  logic          unused_bits;

  assign lo4 = {base_i[DW-1:LW+2], level_i, 2'b00};
  assign lo8 = {base_i[DW-1:LW+3], level_i, 3'b000};
  assign unused_bits = ^base_i[LW+1:0];

  always_comb begin
    unique case (phase_i)
      PH_FIRST: byte_o = DW'(CALL_OP);
      PH_LOW:   byte_o = interval8_i ? lo8 : lo4;
      default:  byte_o = high_i;
    endcase
  end
endmodule

// File: rtl/iack_cas.sv
module iack_cas #(
  parameter int LW = 3
) (
  input  logic          drive_en_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] cas_i,
  input  logic [LW-1:0] own_id_i,
  output logic [LW-1:0] cas_o,
  output logic          match_o
);
  assign cas_o   = drive_en_i ? level_i : '0;
  assign match_o = (cas_i == own_id_i);
endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3,
  localparam int NL = 1 << LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inta_i,
  input  logic          req_valid_i,
  input  logic [LW-1:0] req_level_i,
  input  logic [DW-1:0] vec_base_i,
  input  logic [DW-1:0] vec_high_i,
  input  logic          interval8_i,
  input  logic          auto_eoi_i,
  input  logic          cascade_en_i,
  input  logic          master_i,
  input  logic [NL-1:0] slave_map_i,
  input  logic [LW-1:0] own_id_i,
  input  logic [LW-1:0] cas_i,
  output logic [LW-1:0] cas_o,
  output logic          accept_o,
  output logic [LW-1:0] accept_level_o,
  output logic          eoi_o,
  output logic [LW-1:0] eoi_level_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  logic rise, fall, match, is_master, is_slave, grab_m, grab_s, grab, wrap, drive;
  ph_e  phase;
  logic [LW-1:0] lvl_q;
  logic took_q, live_q, sel_q;
  logic [DW-1:0] vec_byte;

  iack_phase i_phase (
    .clk_i, .rst_ni, .inta_i, .rise_o(rise), .fall_o(fall), .phase_o(phase)
  );

  iack_vector #(.DW(DW), .LW(LW)) i_vector (
    .phase_i(phase), .level_i(lvl_q), .interval8_i, .base_i(vec_base_i),
    .high_i(vec_high_i), .byte_o(vec_byte)
  );

  iack_cas #(.LW(LW)) i_cas (
    .drive_en_i(is_master & cascade_en_i & live_q), .level_i(lvl_q),
    .cas_i, .own_id_i, .cas_o, .match_o(match)
  );

  assign is_master = ~cascade_en_i | master_i;
  assign is_slave  = cascade_en_i & ~master_i;
  assign grab_m    = is_master & rise & (phase == PH_FIRST);
  assign grab_s    = is_slave & fall & (phase == PH_FIRST) & match;
  assign grab      = grab_m | grab_s;
  assign wrap      = fall & (phase == PH_HIGH);

  assign accept_o       = grab & req_valid_i;
  assign accept_level_o = req_level_i;
  assign eoi_o          = rise & (phase == PH_HIGH) & auto_eoi_i & took_q;
  assign eoi_level_o    = lvl_q;

  // opcode from master/single; address bytes from owner of the level
  assign drive     = (phase == PH_FIRST) ? is_master : (is_master ? ~live_q : sel_q);
  assign data_oe_o = inta_i & drive;
  assign data_o    = data_oe_o ? vec_byte : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '1;
      took_q <= 1'b0;
      live_q <= 1'b0;
      sel_q  <= 1'b0;
    end else if (grab) begin
      lvl_q  <= req_valid_i ? req_level_i : '1;
      took_q <= req_valid_i;
      live_q <= grab_m & cascade_en_i & req_valid_i & slave_map_i[req_level_i];
      sel_q  <= grab_s;
    end else if (wrap) begin
      took_q <= 1'b0;
      live_q <= 1'b0;
      sel_q  <= 1'b0;
    end
  end

  AST_OE_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> inta_i); // R8
  AST_OPCODE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && phase == PH_FIRST) |-> data_o == DW'(CALL_OP)); // R2
  AST_LOW_ALIGN8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && phase == PH_LOW && interval8_i) |-> data_o[2:0] == 3'b000); // R4
  AST_EOI_NEEDS_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> auto_eoi_i); // R6
  AST_ACCEPT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o); // R2
  AST_SLAVE_NO_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slave && phase == PH_FIRST) |-> !data_oe_o); // R10
  AST_CAS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cascade_en_i |-> cas_o == '0); // R9
endmodule

// File: tb/test_iack_seq.sv
module test_iack_seq;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0, inta = 0, req_valid = 0, interval8 = 0, auto_eoi = 0;
  logic cascade_en = 0, master = 0;
  logic [2:0] req_level = 0, own_id = 0, cas_in = 0;
  logic [7:0] vec_base = 0, vec_high = 0, slave_map = 0;
  logic [2:0] cas_o, accept_level, eoi_level;
  logic accept, eoi, data_oe;
  logic [7:0] data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iack_seq i_iack_seq (
    .clk_i(clk), .rst_ni, .inta_i(inta), .req_valid_i(req_valid), .req_level_i(req_level),
    .vec_base_i(vec_base), .vec_high_i(vec_high), .interval8_i(interval8),
    .auto_eoi_i(auto_eoi), .cascade_en_i(cascade_en), .master_i(master),
    .slave_map_i(slave_map), .own_id_i(own_id), .cas_i(cas_in), .cas_o,
    .accept_o(accept), .accept_level_o(accept_level), .eoi_o(eoi),
    .eoi_level_o(eoi_level), .data_o(data), .data_oe_o(data_oe)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare bus against scoreboard mid-pulse
  always @(posedge inta) begin
    logic [8:0] e;
    string t;
    #2;
    if (exp_q.size() == 0) check("R8 unexpected pulse", 16'(data_oe), 16'hFFFF);
    else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, 16'(data_oe), 16'(e[8]));
      if (e[8]) check(t, 16'(data), 16'(e[7:0]));
    end
  end

  // driver: push expected bus item, run one pulse, check handshakes
  task automatic pulse(string tag, bit e_oe, logic [7:0] e_byte,
                       bit e_acc_r, bit e_acc_f, bit e_eoi, logic [2:0] e_lvl);
    exp_q.push_back({e_oe, e_byte});
    tag_q.push_back(tag);
    @(negedge clk); inta = 1;
    #1;
    check({tag, " accept at rise"}, 16'(accept), 16'(e_acc_r));
    if (e_acc_r) check({tag, " accept level"}, 16'(accept_level), 16'(e_lvl));
    check({tag, " eoi"}, 16'(eoi), 16'(e_eoi));
    if (e_eoi) check({tag, " eoi level"}, 16'(eoi_level), 16'(e_lvl));
    @(negedge clk); @(negedge clk); inta = 0;
    #1;
    check({tag, " accept at fall"}, 16'(accept), 16'(e_acc_f));
    check({tag, " oe low between pulses"}, 16'(data_oe), 16'h0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe after reset", 16'(data_oe), 16'h0);
    check("R1 accept after reset", 16'(accept), 16'h0);
    check("R1 cas after reset", 16'(cas_o), 16'h0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 eoi after reset", 16'(eoi), 16'h0);

    // single, interval 4, level 5, no auto eoi
    vec_base = 8'hE0; vec_high = 8'h12; req_valid = 1; req_level = 5;
    pulse("R2 opcode single", 1, 8'hCD, 1, 0, 0, 3'd5);
    req_level = 1; // later changes must not matter
    pulse("R3 low byte int4", 1, 8'hF4, 0, 0, 0, 3'd5);
    pulse("R5 high byte", 1, 8'h12, 0, 0, 0, 3'd5);

    // interval 8, level 3, auto eoi
    interval8 = 1; auto_eoi = 1; req_level = 3; vec_high = 8'hA7;
    pulse("R8 restart opcode", 1, 8'hCD, 1, 0, 0, 3'd3);
    pulse("R4 low byte int8", 1, 8'hD8, 0, 0, 0, 3'd3);
    pulse("R6 auto eoi high", 1, 8'hA7, 0, 0, 1, 3'd3);

    // no auto eoi: no release
    auto_eoi = 0; interval8 = 0; req_level = 0; vec_base = 8'h80;
    pulse("R2 opcode level0", 1, 8'hCD, 1, 0, 0, 3'd0);
    pulse("R3 low byte level0", 1, 8'h80, 0, 0, 0, 3'd0);
    pulse("R6 no eoi when off", 1, 8'h12 ^ 8'h12 ^ vec_high, 0, 0, 0, 3'd0);

    // spurious
    auto_eoi = 1; req_valid = 0; vec_base = 8'h40;
    pulse("R7 spurious opcode", 1, 8'hCD, 0, 0, 0, 3'd7);
    pulse("R7 spurious low", 1, 8'h5C, 0, 0, 0, 3'd7);
    pulse("R7 spurious no eoi", 1, vec_high, 0, 0, 0, 3'd7);

    // master with slave on level 2
    auto_eoi = 0; req_valid = 1; req_level = 2; cascade_en = 1; master = 1;
    slave_map = 8'h04;
    pulse("R9 master opcode", 1, 8'hCD, 1, 0, 0, 3'd2);
    check("R9 cas lines", 16'(cas_o), 16'h2);
    pulse("R9 master silent low", 0, 8'h00, 0, 0, 0, 3'd2);
    check("R9 cas held", 16'(cas_o), 16'h2);
    pulse("R9 master silent high", 0, 8'h00, 0, 0, 0, 3'd2);
    check("R9 cas cleared", 16'(cas_o), 16'h0);

    // master, level without slave
    req_level = 4; vec_base = 8'h00;
    pulse("R9 master own opcode", 1, 8'hCD, 1, 0, 0, 3'd4);
    check("R9 cas idle no slave", 16'(cas_o), 16'h0);
    pulse("R9 master own low", 1, 8'h10, 0, 0, 0, 3'd4);
    pulse("R9 master own high", 1, vec_high, 0, 0, 0, 3'd4);

    // selected slave
    master = 0; own_id = 4; cas_in = 4; req_level = 6; vec_base = 8'h20; vec_high = 8'h3B;
    pulse("R10 slave no opcode", 0, 8'h00, 0, 1, 0, 3'd6);
    pulse("R10 slave low", 1, 8'h38, 0, 0, 0, 3'd6);
    pulse("R10 slave high", 1, 8'h3B, 0, 0, 0, 3'd6);

    // unselected slave
    cas_in = 1;
    pulse("R10 other slave p1", 0, 8'h00, 0, 0, 0, 3'd6);
    pulse("R10 other slave p2", 0, 8'h00, 0, 0, 0, 3'd6);
    pulse("R10 other slave p3", 0, 8'h00, 0, 0, 0, 3'd6);

    cascade_en = 0;
    @(negedge clk);
    check("R9 cas zero when single", 16'(cas_o), 16'h0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule